// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the arithmetic and logic stage of a simple load/store processor datapath. It takes two operands of a parameterised width (32 bits by default), a 4-bit operation code and the current condition flags. It returns a result, a write-enable for the destination register and the next set of flags. Sixteen operations are covered:

- Four additions and subtractions, in plain and carry-using forms.
- Two reversed subtractions, again in plain and carry-using forms.
- Four bitwise operations.
- Two move operations.
- Four compare/test operations. These exist only to update the flags.

The block is purely combinational. The surrounding pipeline owns the flag storage and feeds the stored flags back in on `flags_in`. The flags it receives back on `flags_out` are either freshly computed or passed through unchanged. A `set_flags` request decides which ordinary operations update the flags. Operand shifting, register reads and writes, and condition evaluation are handled elsewhere.

One parameter chooses how the adder is built. It can be a single behavioural addition or an explicit bit-level ripple chain made with a generate loop. Both forms give the same results.

Top module: `alu_dp`

## Requirements
- R1: Opcode 0 (add) gives A + B and opcode 1 (add with carry) gives A + B + C. In both, C is the carry flag on `flags_in[1]`, and the result is taken modulo 2^WIDTH.
- R2: Opcode 2 (subtract) gives A − B and opcode 3 (subtract with carry) gives A − B + C − 1, modulo 2^WIDTH.
- R3: Opcode 4 (reverse subtract) gives B − A and opcode 5 (reverse subtract with carry) gives B − A + C − 1, modulo 2^WIDTH.
- R4: The bitwise operations are as follows:
  - Opcode 6 gives A AND B.
  - Opcode 7 gives A OR B.
  - Opcode 8 gives A XOR B.
  - Opcode 9 gives A AND NOT B, so every 1 bit of B clears the matching bit of A.
- R5: Opcode 10 passes B through unchanged and opcode 11 outputs the bitwise inverse of B.
- R6: Opcodes 12 to 15 are the compare/test operations. They compute A − B, A + B, A AND B and A XOR B respectively, with the value shown on `result`. They hold `wr_en` low and always update the flags, whatever `set_flags` is. `wr_en` is high for opcodes 0 to 11.
- R7: The flag vector holds N at bit 3, Z at bit 2, C at bit 1 and V at bit 0. When the flags are updated, N equals the top bit of `result`, and Z is 1 exactly when `result` is all zeros.
- R8: When the flags are updated by an arithmetic operation (opcodes 0 to 5, 12 and 13), C and V are set as follows:
  - For additions, C is the unsigned carry out.
  - For subtractions, C is 1 when no borrow occurs.
  - V is 1 on signed two's-complement overflow.
- R9: When the flags are updated by a bitwise, move or test operation (opcodes 6 to 11, 14 and 15), C and V keep their values from `flags_in`.
- R10: When `set_flags` is low and the opcode is 0 to 11, `flags_out` equals `flags_in`.
- R11: Results, write-enable and flags are the same for both adder variants (ADDER_RIPPLE 0 or 1) and at any WIDTH of 2 or more. A WIDTH below 2 is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | WIDTH | First operand A |
| opb | input | WIDTH | Second operand B |
| opcode | input | 4 | Operation select, encoded as in R1 to R6 |
| flags_in | input | 4 | Current flags {N,Z,C,V}; bit 1 is the carry used by the carry forms |
| set_flags | input | 1 | Request a flag update for opcodes 0 to 11 |
| result | output | WIDTH | Operation result |
| wr_en | output | 1 | Destination register write-enable |
| flags_out | output | 4 | Next flags {N,Z,C,V} |

## Verification
The bench builds the block twice at WIDTH 4, once with each adder variant. Operand space, opcode and carry are small enough there to sweep every A and B under every opcode, several incoming flag patterns and both values of `set_flags`. That sweep reaches every carry, borrow and signed-overflow boundary. The two 4-bit builds are also compared against each other cycle by cycle. A third build at WIDTH 32 with the ripple adder runs directed boundary pairs, such as all-ones plus one and the most negative value minus one, so the full-width carry chain and sign bit are exercised.

// File: rtl/alu_dp_pkg.sv
package alu_dp_pkg;

   typedef enum logic [3:0] {
      OP_ADD      = 4'd0,
      OP_ADDC     = 4'd1,
      OP_SUB      = 4'd2,
      OP_SUBC     = 4'd3,
      OP_RSUB     = 4'd4,
      OP_RSUBC    = 4'd5,
      OP_AND      = 4'd6,
      OP_OR       = 4'd7,
      OP_XOR      = 4'd8,
      OP_ANDN     = 4'd9,
      OP_PASS     = 4'd10,
      OP_INV      = 4'd11,
      OP_CMPSUB   = 4'd12,
      OP_CMPADD   = 4'd13,
      OP_TESTAND  = 4'd14,
      OP_TESTXOR  = 4'd15
   } alu_op_e;

   localparam int FLAG_N = 3;
   localparam int FLAG_Z = 2;
   localparam int FLAG_C = 1;
   localparam int FLAG_V = 0;
   localparam int FLAG_BITS = 4;

endpackage

// File: rtl/alu_dp_adder.sv
module alu_dp_adder #(
   parameter int WIDTH = 32,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [WIDTH-1:0] x,
   input  logic [WIDTH-1:0] y,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout,
   output logic             ovf
);
   localparam int MSB = WIDTH - 1;
   localparam int EXT = WIDTH + 1;

   generate
      if (RIPPLE) begin : g_ripple
         logic [WIDTH:0] carry;
         assign carry[0] = cin;
         for (genvar g = 0; g < WIDTH; g++) begin : g_bit
            assign sum[g]     = x[g] ^ y[g] ^ carry[g];
            assign carry[g+1] = (x[g] & y[g]) | (carry[g] & (x[g] ^ y[g]));
         end
         assign cout = carry[WIDTH];
         assign ovf  = carry[WIDTH] ^ carry[MSB];

         always_comb begin
            assert_chain_sum_R11: assert ({cout, sum} ==
               ({1'b0, x} + {1'b0, y} + EXT'(cin)))
               else $error("ripple chain disagrees with arithmetic sum");
            assert_chain_ovf_R8: assert (ovf ==
               ((x[MSB] == y[MSB]) && (sum[MSB] != x[MSB])))
               else $error("ripple overflow disagrees with sign rule");
         end
      end else begin : g_behav
         logic [WIDTH:0] wide;
         assign wide = {1'b0, x} + {1'b0, y} + EXT'(cin);
         assign sum  = wide[MSB:0];
         assign cout = wide[WIDTH];
         assign ovf  = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);

         always_comb begin
            assert_behav_ovf_R8: assert (ovf ==
               (cout ^ (x[MSB] ^ y[MSB] ^ sum[MSB])))
               else $error("overflow disagrees with carry-in/out of sign bit");
         end
      end
   endgenerate

endmodule

// File: rtl/alu_dp_logic.sv
module alu_dp_logic
   import alu_dp_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  alu_op_e          op,
   output logic [WIDTH-1:0] res
);
   always_comb begin
      unique case (op)
         OP_AND, OP_TESTAND: res = a & b;
         OP_OR:              res = a | b;
         OP_XOR, OP_TESTXOR: res = a ^ b;
         OP_ANDN:            res = a & ~b;
         OP_PASS:            res = b;
         OP_INV:             res = ~b;
         default:            res = '0;
      endcase
   end

   always_comb begin
      if (op == OP_ANDN) begin
         assert_andn_clears_R4: assert ((res & b) == '0)
            else $error("bit-clear left a bit set where B is one");
      end
   end

endmodule

// File: rtl/alu_dp_flags.sv
module alu_dp_flags
   import alu_dp_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0]     res,
   input  logic                 cout,
   input  logic                 ovf,
   input  logic                 arith,
   input  logic                 upd,
   input  logic [FLAG_BITS-1:0] flags_in,
   output logic [FLAG_BITS-1:0] flags_out
);
   always_comb begin
      flags_out = flags_in;
      if (upd) begin
         flags_out[FLAG_N] = res[WIDTH-1];
         flags_out[FLAG_Z] = ~|res;
         if (arith) begin
            flags_out[FLAG_C] = cout;
            flags_out[FLAG_V] = ovf;
         end
      end
   end

endmodule

// File: rtl/alu_dp.sv
module alu_dp
   import alu_dp_pkg::*;
#(
   parameter int WIDTH        = 32,
   parameter bit ADDER_RIPPLE = 1'b0
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic [3:0]       opcode,
   input  logic [3:0]       flags_in,
   input  logic             set_flags,
   output logic [WIDTH-1:0] result,
   output logic             wr_en,
   output logic [3:0]       flags_out
);
   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("alu_dp: WIDTH must be at least 2");
      end
   endgenerate

   alu_op_e          op;
   logic [WIDTH-1:0] add_x;
   logic [WIDTH-1:0] add_y;
   logic             add_cin;
   logic             is_arith;
   logic             is_cmp;
   logic             upd;
   logic [WIDTH-1:0] sum;
   logic             cout;
   logic             ovf;
   logic [WIDTH-1:0] logic_res;
   logic             carry_now;

   assign op        = alu_op_e'(opcode);
   assign carry_now = flags_in[FLAG_C];

   // Operand steering: subtraction is x + ~y + 1, so the carry out
   // of the adder is already the inverted borrow.
   always_comb begin
      add_x    = opa;
      add_y    = opb;
      add_cin  = 1'b0;
      is_arith = 1'b1;
      unique case (op)
         OP_ADD, OP_CMPADD: ;
         OP_ADDC:           add_cin = carry_now;
         OP_SUB, OP_CMPSUB: begin add_y = ~opb; add_cin = 1'b1; end
         OP_SUBC:           begin add_y = ~opb; add_cin = carry_now; end
         OP_RSUB:           begin add_x = opb; add_y = ~opa; add_cin = 1'b1; end
         OP_RSUBC:          begin add_x = opb; add_y = ~opa; add_cin = carry_now; end
         default:           is_arith = 1'b0;
      endcase
   end

   assign is_cmp = (opcode[3:2] == 2'b11);
   assign upd    = set_flags | is_cmp;
   assign wr_en  = ~is_cmp;

   alu_dp_adder #(.WIDTH(WIDTH), .RIPPLE(ADDER_RIPPLE)) adder_i (
      .x    (add_x),
      .y    (add_y),
      .cin  (add_cin),
      .sum  (sum),
      .cout (cout),
      .ovf  (ovf)
   );

   alu_dp_logic #(.WIDTH(WIDTH)) logic_i (
      .a   (opa),
      .b   (opb),
      .op  (op),
      .res (logic_res)
   );

   assign result = is_arith ? sum : logic_res;

   alu_dp_flags #(.WIDTH(WIDTH)) flags_i (
      .res       (result),
      .cout      (cout),
      .ovf       (ovf),
      .arith     (is_arith),
      .upd       (upd),
      .flags_in  (flags_in),
      .flags_out (flags_out)
   );

   always_comb begin
      if (opcode >= 4'd12) begin
         assert_cmp_no_write_R6: assert (!wr_en)
            else $error("compare/test opcode asserted write-enable");
         assert_cmp_updates_R6: assert (flags_out[FLAG_Z] == (result == '0))
            else $error("compare/test did not refresh Z");
      end
      if (!set_flags && opcode < 4'd12) begin
         assert_flags_hold_R10: assert (flags_out == flags_in)
            else $error("flags changed without a set-flags request");
      end
      if (upd) begin
         assert_zero_flag_R7: assert (flags_out[FLAG_Z] == (result == '0))
            else $error("Z flag does not match result");
         assert_neg_flag_R7: assert (flags_out[FLAG_N] == result[MSB])
            else $error("N flag does not match result sign");
      end
      if (upd && !is_arith) begin
         assert_keep_cv_R9: assert (flags_out[1:0] == flags_in[1:0])
            else $error("non-arithmetic operation altered C or V");
      end
      if (op == OP_PASS) begin
         assert_pass_b_R5: assert (result == opb)
            else $error("move did not pass B through");
      end
   end

endmodule

// File: tb/alu_dp_tb.sv
`timescale 1ns/1ps
module alu_dp_tb_top;

   localparam int SW = 4;
   localparam int WW = 32;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [SW-1:0] s_a, s_b, s_res, s_res_b;
   logic          s_we, s_we_b;
   logic [3:0]    s_fo, s_fo_b;
   logic [WW-1:0] w_a, w_b, w_res;
   logic          w_we;
   logic [3:0]    w_fo;
   logic [3:0]    op, fin;
   logic          sf;

   alu_dp #(.WIDTH(SW), .ADDER_RIPPLE(1'b1)) dut_i (
      .opa(s_a), .opb(s_b), .opcode(op), .flags_in(fin), .set_flags(sf),
      .result(s_res), .wr_en(s_we), .flags_out(s_fo));

   alu_dp #(.WIDTH(SW), .ADDER_RIPPLE(1'b0)) dut_b_i (
      .opa(s_a), .opb(s_b), .opcode(op), .flags_in(fin), .set_flags(sf),
      .result(s_res_b), .wr_en(s_we_b), .flags_out(s_fo_b));

   alu_dp #(.WIDTH(WW), .ADDER_RIPPLE(1'b1)) dut_w_i (
      .opa(w_a), .opb(w_b), .opcode(op), .flags_in(fin), .set_flags(sf),
      .result(w_res), .wr_en(w_we), .flags_out(w_fo));

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s op=%0d actual=%0h expected=%0h", tag, what, op, act, exp);
      end
   endtask

   function automatic string op_tag(input int o);
      if (o <= 1) return "R1";
      if (o <= 3) return "R2";
      if (o <= 5) return "R3";
      if (o <= 9) return "R4";
      if (o <= 11) return "R5";
      return "R6";
   endfunction

   // Arithmetic reference built from unsigned and signed integer values.
   function automatic void model(input int w, input int o, input longint a,
                                 input longint b, input logic [3:0] fi,
                                 input bit sfl, output longint res,
                                 output bit we, output logic [3:0] fo);
      longint m  = (longint'(1) << w) - 1;
      longint h  = longint'(1) << (w - 1);
      longint sa = (a >= h) ? a - (m + 1) : a;
      longint sb = (b >= h) ? b - (m + 1) : b;
      longint c  = longint'(fi[1]);
      longint ur = 0;
      longint sr = 0;
      bit ar = 1'b1;
      bit is_add = 1'b0;
      bit cc, vv, upd;
      case (o)
         0, 13: begin ur = a + b;         sr = sa + sb;         is_add = 1'b1; end
         1:     begin ur = a + b + c;     sr = sa + sb + c;     is_add = 1'b1; end
         2, 12: begin ur = a - b;         sr = sa - sb;         end
         3:     begin ur = a - b + c - 1; sr = sa - sb + c - 1; end
         4:     begin ur = b - a;         sr = sb - sa;         end
         5:     begin ur = b - a + c - 1; sr = sb - sa + c - 1; end
         default: ar = 1'b0;
      endcase
      if (ar) res = ur & m;
      else case (o)
         6, 14:   res = a & b;
         7:       res = a | b;
         8, 15:   res = a ^ b;
         9:       res = a & (~b & m);
         10:      res = b;
         default: res = ~b & m;
      endcase
      cc  = is_add ? (ur > m) : (ur >= 0);
      vv  = (sr > h - 1) || (sr < -h);
      we  = (o < 12);
      upd = sfl || (o >= 12);
      fo  = fi;
      if (upd) begin
         fo[3] = ((res >> (w - 1)) & 1) != 0;
         fo[2] = (res == 0);
         if (ar) begin fo[1] = cc; fo[0] = vv; end
      end
   endfunction

   task automatic check_outputs(input int w, input longint a, input longint b,
                                input longint r_act, input bit we_act,
                                input logic [3:0] fo_act);
      longint r_exp;
      bit we_exp;
      logic [3:0] fo_exp;
      bit arith;
      model(w, int'(op), a, b, fin, sf, r_exp, we_exp, fo_exp);
      arith = (op <= 4'd5) || (op == 4'd12) || (op == 4'd13);
      chk(r_act == r_exp, op_tag(int'(op)), "result", r_act, r_exp);
      chk(we_act == we_exp, "R6", "wr_en", longint'(we_act), longint'(we_exp));
      if (!sf && op < 4'd12)
         chk(fo_act == fo_exp, "R10", "flags held", longint'(fo_act), longint'(fo_exp));
      else begin
         chk(fo_act[3:2] == fo_exp[3:2], "R7", "N/Z", longint'(fo_act), longint'(fo_exp));
         if (arith)
            chk(fo_act[1:0] == fo_exp[1:0], "R8", "C/V", longint'(fo_act), longint'(fo_exp));
         else
            chk(fo_act[1:0] == fo_exp[1:0], "R9", "C/V kept", longint'(fo_act), longint'(fo_exp));
      end
   endtask

   function automatic logic [WW-1:0] pick_a(input int i);
      case (i)
         0: return 32'h0000_0000;
         1: return 32'hFFFF_FFFF;
         2: return 32'h7FFF_FFFF;
         3: return 32'h8000_0000;
         4: return 32'h8000_0000;
         5: return 32'h1357_9BDF;
         6: return 32'hE1E1_3C3C;
         default: return 32'h0000_0001;
      endcase
   endfunction

   function automatic logic [WW-1:0] pick_b(input int i);
      case (i)
         0: return 32'h0000_0000;
         1: return 32'h0000_0001;
         2: return 32'h0000_0001;
         3: return 32'h0000_0001;
         4: return 32'h8000_0000;
         5: return 32'h1357_9BDF;
         6: return 32'h0FF0_5AA5;
         default: return 32'hFFFF_FFFF;
      endcase
   endfunction

   initial begin
      s_a = '0; s_b = '0; w_a = '0; w_b = '0; op = '0; fin = '0; sf = 1'b0;
      @(negedge clk);
      // Idle state with all-zero inputs: add of zeros, flags untouched.
      chk(s_res == '0 && s_we && s_fo == 4'h0, "R10", "idle outputs",
          longint'({s_res, s_we, s_fo}), longint'(9'b0000_1_0000));

      // Exhaustive 4-bit sweep over both adder variants.
      for (int o = 0; o < 16; o++)
         for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
               for (int f = 0; f < 4; f++)
                  for (int s = 0; s < 2; s++) begin
                     @(posedge clk);
                     op  = 4'(o);
                     s_a = SW'(a);
                     s_b = SW'(b);
                     fin = {a[3] ^ f[0], b[1], f[1], f[0] ^ s[0]};
                     sf  = s[0];
                     @(negedge clk);
                     check_outputs(SW, longint'(s_a), longint'(s_b), longint'(s_res), s_we, s_fo);
                     chk(s_res == s_res_b && s_we == s_we_b && s_fo == s_fo_b, "R11",
                         "ripple vs behavioural", longint'({s_res, s_we, s_fo}),
                         longint'({s_res_b, s_we_b, s_fo_b}));
                  end

      // Directed 32-bit boundary pairs.
      for (int p = 0; p < 8; p++)
         for (int o = 0; o < 16; o++)
            for (int f = 0; f < 4; f++)
               for (int s = 0; s < 2; s++) begin
                  @(posedge clk);
                  op  = 4'(o);
                  w_a = pick_a(p);
                  w_b = pick_b(p);
                  fin = {f[0], f[1], f[1], f[0] ^ s[0]};
                  sf  = s[0];
                  @(negedge clk);
                  // R11: full-width build checked against the same reference
                  check_outputs(WW, longint'(w_a), longint'(w_b), longint'(w_res), w_we, w_fo);
               end

      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule